// File: doc/BRIEF.md
# LSB-First Serial Register Access Port

This block is a chip-select framed serial slave that lets a host read and write a small bank of 8-bit registers at addresses 0 through 10. The host pulls CS low, shifts an 8-bit command byte in least significant bit first, then moves data bytes. A single access moves one byte. A burst access moves consecutive bytes, starting at address 0. Raising CS ends any access at once.

The serial pins are sampled by the block's own clock through a short synchronizer. SCLK is handled as a data signal, and only its detected edges advance the logic. Toward the register file the port drives an address, write data and a one-cycle write strobe. For reads it drives a one-cycle fetch strobe and takes the read data combinationally in that same cycle. A separate flag marks fetches that belong to a burst, so that the register file can leave read-to-clear status untouched during burst polling. What the registers hold and what they mean is outside this block.

Top module: `lsb_reg_port`

## Requirements
- R1: The command byte is received least significant bit first. Bit 0 selects the direction, with 1 meaning read and 0 meaning write. Bits 4:1 give the register address, with bit 1 as its LSB. Bit 7 requests a burst.
- R2: In a write, the 8 data bits after the command are received LSB first on SCLK rising edges. Exactly one `reg_we_o` pulse of one cycle then carries the address and the assembled byte. A single access ignores any later bytes.
- R3: A read issues one `reg_re_o` fetch after the command byte. SDO then presents the fetched byte LSB first. Bit k appears after the (k+1)-th SCLK falling edge that follows the last command rising edge.
- R4: SDO changes only in response to an SCLK falling edge, and it holds its value until the next falling edge.
- R5: When bit 7 of the command is set and the address is 0, every further byte goes to the next address, in the order 0, 1, 2 and onward. When bit 7 is set with a nonzero address, the access is a normal single access.
- R6: After address 10 a burst stops advancing. Further burst reads return 0x00 and issue no fetch, and further burst writes issue no strobe. A single access to addresses 11 to 15 behaves the same way.
- R7: A command with bit 5 or bit 6 set is rejected. It produces no write strobe and no fetch, and SDO stays disabled until CS rises.
- R8: `sdo_oe_o` is high only during the data phase of an accepted read while CS is low. It is low during the command byte, during writes and while CS is high.
- R9: A CS rise aborts the access. A partly received data byte is dropped without a write strobe, and the next CS low starts a new command.
- R10: `reg_rd_burst_o` is high together with each fetch made inside a burst. It stays low for the fetch of a single read.
- R11: While `rst_ni` is low, `reg_we_o`, `reg_re_o`, `reg_rd_burst_o` and `sdo_oe_o` are low.
- R12: SCLK and SDI activity while CS is high has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock that samples the serial pins |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| sclk_i | input | 1 | Serial clock from the host |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable for the SDO driver |
| reg_addr_o | output | ADDR_W | Register address for the strobe or fetch |
| reg_wdata_o | output | DATA_W | Write data |
| reg_we_o | output | 1 | Write strobe, one cycle |
| reg_re_o | output | 1 | Read fetch strobe, one cycle |
| reg_rdata_i | input | DATA_W | Read data, sampled while `reg_re_o` is high |
| reg_rd_burst_o | output | 1 | The current fetch belongs to a burst |

## Verification
On every cycle the assertions check the following. The write and fetch strobes never coincide. A write strobe lasts a single cycle. No strobe or fetch leaves the address range. SDO stays disabled while CS is deasserted and never drives during a write strobe. SDO moves only after a detected falling SCLK edge. Bit order, the address walk of a burst, the zero fill past address 10, rejection of reserved commands, dropping of a cut-off byte and the burst flag count can only be shown by the bench's complete transfers.

// File: rtl/lsb_port_pkg.sv
package lsb_port_pkg;
  typedef enum logic [1:0] {
    PH_CMD  = 2'd0,
    PH_DATA = 2'd1,
    PH_DONE = 2'd2
  } phase_e;

  localparam int CMD_RW_BIT    = 0;
  localparam int CMD_ADDR_LSB  = 1;
  localparam int CMD_RSV_LSB   = 5;
  localparam int CMD_RSV_W     = 2;
  localparam int CMD_BURST_BIT = 7;
endpackage

// File: rtl/lsb_port_sync.sv
module lsb_port_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic cs_ni,
  input  logic sdi_i,
  output logic sclk_rise_o,
  output logic sclk_fall_o,
  output logic cs_act_o,
  output logic sdi_o
);
  localparam int W = 3;
  localparam logic [W-1:0] IDLE = 3'b010; // {sdi, cs_n, sclk}

  logic [STAGES-1:0][W-1:0] chain;
  logic                     sclk_prev;
  logic [W-1:0]             last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain     <= {STAGES{IDLE}};
      sclk_prev <= 1'b0;
    end else begin
      chain[0] <= {sdi_i, cs_ni, sclk_i};
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      sclk_prev <= chain[STAGES-1][0];
    end
  end

  assign last        = chain[STAGES-1];
  assign cs_act_o    = ~last[1];
  assign sdi_o       = last[2];
  assign sclk_rise_o = cs_act_o & last[0] & ~sclk_prev;
  assign sclk_fall_o = cs_act_o & ~last[0] & sclk_prev;
endmodule

// File: rtl/lsb_port_addr.sv
module lsb_port_addr #(
  parameter int ADDR_W    = 4,
  parameter int LAST_ADDR = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic              step_i,
  output logic              load_past_o,
  output logic [ADDR_W-1:0] ptr_o,
  output logic              past_o,
  output logic [ADDR_W-1:0] nxt_ptr_o,
  output logic              nxt_past_o
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(LAST_ADDR);

  logic [ADDR_W-1:0] ptr_q;
  logic              past_q;

  assign load_past_o = load_addr_i > LAST;

  always_comb begin
    nxt_ptr_o  = ptr_q;
    nxt_past_o = 1'b1;
    if (!past_q && ptr_q != LAST) begin
      nxt_ptr_o  = ptr_q + 1'b1;
      nxt_past_o = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      past_q <= 1'b0;
    end else if (load_i) begin
      ptr_q  <= load_addr_i;
      past_q <= load_past_o;
    end else if (step_i) begin
      ptr_q  <= nxt_ptr_o;
      past_q <= nxt_past_o;
    end
  end

  assign ptr_o  = ptr_q;
  assign past_o = past_q;
endmodule

// File: rtl/lsb_port_ctrl.sv
module lsb_port_ctrl
  import lsb_port_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 4,
  parameter int LAST_ADDR = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_act_i,
  input  logic              sclk_rise_i,
  input  logic              sdi_i,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  output logic              reg_we_o,
  output logic              fetch_o,
  output logic              fetch_zero_o,
  output logic              fetch_burst_o,
  output logic              rd_phase_o
);
  localparam int CNT_W = $clog2(DATA_W);

  phase_e            phase_q;
  logic [CNT_W-1:0]  bit_cnt_q;
  logic [DATA_W-1:0] rx_q, rx_next;
  logic              is_rd_q, burst_q;
  logic              we_q, fetch_q, zero_q, fburst_q;
  logic [ADDR_W-1:0] out_addr_q;
  logic [DATA_W-1:0] wdata_q;

  logic              byte_done, cmd_rw, cmd_bm, cmd_ok, cmd_burst;
  logic [ADDR_W-1:0] cmd_addr;
  logic              load, step, load_past, past, nxt_past;
  logic [ADDR_W-1:0] ptr, nxt_ptr;

  always_comb begin
    rx_next   = {sdi_i, rx_q[DATA_W-1:1]};
    byte_done = sclk_rise_i && (bit_cnt_q == CNT_W'(DATA_W-1));
    cmd_rw    = rx_next[CMD_RW_BIT];
    cmd_addr  = rx_next[CMD_ADDR_LSB +: ADDR_W];
    cmd_bm    = rx_next[CMD_BURST_BIT];
    cmd_ok    = rx_next[CMD_RSV_LSB +: CMD_RSV_W] == '0;
    cmd_burst = cmd_bm && (cmd_addr == '0);
    load      = cs_act_i && byte_done && (phase_q == PH_CMD) && cmd_ok;
    step      = cs_act_i && byte_done && (phase_q == PH_DATA) && burst_q;
  end

  lsb_port_addr #(.ADDR_W(ADDR_W), .LAST_ADDR(LAST_ADDR)) u_addr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .load_addr_i (cmd_addr),
    .step_i      (step),
    .load_past_o (load_past),
    .ptr_o       (ptr),
    .past_o      (past),
    .nxt_ptr_o   (nxt_ptr),
    .nxt_past_o  (nxt_past)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q    <= PH_CMD;
      bit_cnt_q  <= '0;
      rx_q       <= '0;
      is_rd_q    <= 1'b0;
      burst_q    <= 1'b0;
      we_q       <= 1'b0;
      fetch_q    <= 1'b0;
      zero_q     <= 1'b0;
      fburst_q   <= 1'b0;
      out_addr_q <= '0;
      wdata_q    <= '0;
    end else begin
      we_q    <= 1'b0;
      fetch_q <= 1'b0;
      if (!cs_act_i) begin
        phase_q   <= PH_CMD;
        bit_cnt_q <= '0;
        is_rd_q   <= 1'b0;
        burst_q   <= 1'b0;
      end else if (sclk_rise_i) begin
        rx_q      <= rx_next;
        bit_cnt_q <= byte_done ? '0 : bit_cnt_q + 1'b1;
        if (byte_done) begin
          unique case (phase_q)
            PH_CMD: begin
              if (!cmd_ok) begin
                phase_q <= PH_DONE;
              end else begin
                phase_q <= PH_DATA;
                is_rd_q <= cmd_rw;
                burst_q <= cmd_burst;
                if (cmd_rw) begin
                  fetch_q    <= 1'b1;
                  zero_q     <= load_past;
                  fburst_q   <= cmd_burst;
                  out_addr_q <= cmd_addr;
                end
              end
            end
            PH_DATA: begin
              if (!is_rd_q && !past) begin
                we_q       <= 1'b1;
                out_addr_q <= ptr;
                wdata_q    <= rx_next;
              end
              if (!burst_q) begin
                phase_q <= PH_DONE;
              end else if (is_rd_q) begin
                fetch_q    <= 1'b1;
                zero_q     <= nxt_past;
                fburst_q   <= 1'b1;
                out_addr_q <= nxt_ptr;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  assign reg_addr_o    = out_addr_q;
  assign reg_wdata_o   = wdata_q;
  assign reg_we_o      = we_q;
  assign fetch_o       = fetch_q;
  assign fetch_zero_o  = zero_q;
  assign fetch_burst_o = fburst_q;
  assign rd_phase_o    = cs_act_i && is_rd_q && (phase_q == PH_DATA);
endmodule

// File: rtl/lsb_port_tx.sv
module lsb_port_tx #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_fall_i,
  input  logic              rd_phase_i,
  input  logic              load_i,
  input  logic              load_zero_i,
  input  logic [DATA_W-1:0] load_data_i,
  output logic              sdo_o,
  output logic              sdo_oe_o
);
  logic [DATA_W-1:0] sh_q;
  logic              sdo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      sdo_q <= 1'b0;
    end else if (load_i) begin
      sh_q <= load_zero_i ? '0 : load_data_i;
    end else if (sclk_fall_i && rd_phase_i) begin
      sdo_q <= sh_q[0];
      sh_q  <= {1'b0, sh_q[DATA_W-1:1]};
    end
  end

  assign sdo_o    = sdo_q;
  assign sdo_oe_o = rd_phase_i;
endmodule

// File: rtl/lsb_reg_port.sv
module lsb_reg_port #(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 4,
  parameter int LAST_ADDR   = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  output logic              reg_we_o,
  output logic              reg_re_o,
  input  logic [DATA_W-1:0] reg_rdata_i,
  output logic              reg_rd_burst_o
);
  logic sclk_rise, sclk_fall, cs_act, sdi_s;
  logic fetch, fetch_zero, fetch_burst, rd_phase;

  lsb_port_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sclk_i      (sclk_i),
    .cs_ni       (cs_ni),
    .sdi_i       (sdi_i),
    .sclk_rise_o (sclk_rise),
    .sclk_fall_o (sclk_fall),
    .cs_act_o    (cs_act),
    .sdi_o       (sdi_s)
  );

  lsb_port_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LAST_ADDR(LAST_ADDR)) u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cs_act_i      (cs_act),
    .sclk_rise_i   (sclk_rise),
    .sdi_i         (sdi_s),
    .reg_addr_o    (reg_addr_o),
    .reg_wdata_o   (reg_wdata_o),
    .reg_we_o      (reg_we_o),
    .fetch_o       (fetch),
    .fetch_zero_o  (fetch_zero),
    .fetch_burst_o (fetch_burst),
    .rd_phase_o    (rd_phase)
  );

  lsb_port_tx #(.DATA_W(DATA_W)) u_tx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sclk_fall_i (sclk_fall),
    .rd_phase_i  (rd_phase),
    .load_i      (fetch),
    .load_zero_i (fetch_zero),
    .load_data_i (reg_rdata_i),
    .sdo_o       (sdo_o),
    .sdo_oe_o    (sdo_oe_o)
  );

  // past-end fetches load zero and stay invisible to the register file
  assign reg_re_o       = fetch & ~fetch_zero;
  assign reg_rd_burst_o = reg_re_o & fetch_burst;
endmodule

// File: rtl/lsb_reg_port_chk.sv
module lsb_reg_port_chk #(
  parameter int ADDR_W    = 4,
  parameter int LAST_ADDR = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_act_i,
  input logic              sclk_fall_i,
  input logic              reg_we_i,
  input logic              reg_re_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic              sdo_i,
  input logic              sdo_oe_i
);
  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_we_i && reg_re_i)); // R2
  AST_WE_SINGLE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i |=> !reg_we_i); // R2
  AST_WE_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i |-> (int'(reg_addr_i) <= LAST_ADDR)); // R6
  AST_RE_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_re_i |-> (int'(reg_addr_i) <= LAST_ADDR)); // R6
  AST_SDO_OFF_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_act_i |-> !sdo_oe_i); // R8
  AST_SDO_OFF_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i |-> !sdo_oe_i); // R8
  AST_SDO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(sclk_fall_i) |-> $stable(sdo_i)); // R4
endmodule

bind lsb_reg_port lsb_reg_port_chk #(.ADDR_W(ADDR_W), .LAST_ADDR(LAST_ADDR)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cs_act_i    (cs_act),
  .sclk_fall_i (sclk_fall),
  .reg_we_i    (reg_we_o),
  .reg_re_i    (reg_re_o),
  .reg_addr_i  (reg_addr_o),
  .sdo_i       (sdo_o),
  .sdo_oe_i    (sdo_oe_o)
);

// File: tb/lsb_reg_port_tb_top.sv
module lsb_reg_port_tb_top;
  localparam int HALF = 8;
  localparam int NVEC = 12;
  // {cmd, wdata, expect strobe/fetch, expect sdo enabled, expect read byte}
  localparam logic [25:0] VEC [NVEC] = '{
    {8'h06, 8'hA5, 1'b1, 1'b0, 8'h00},  // R2 write addr 3
    {8'h07, 8'h00, 1'b1, 1'b1, 8'hA5},  // R3 read addr 3
    {8'h14, 8'h3C, 1'b1, 1'b0, 8'h00},  // R1 write addr 10
    {8'h15, 8'h00, 1'b1, 1'b1, 8'h3C},  // R1 read addr 10
    {8'h18, 8'hFF, 1'b0, 1'b0, 8'h00},  // R6 write addr 12 ignored
    {8'h19, 8'h00, 1'b0, 1'b1, 8'h00},  // R6 read addr 12 gives zero
    {8'h2A, 8'h77, 1'b0, 1'b0, 8'h00},  // R7 reserved bit 5
    {8'h47, 8'h00, 1'b0, 1'b0, 8'h00},  // R7 reserved bit 6
    {8'h86, 8'h11, 1'b1, 1'b0, 8'h00},  // R5 burst bit, addr 3: single
    {8'h07, 8'h00, 1'b1, 1'b1, 8'h11},  // R5 read back
    {8'h01, 8'h00, 1'b1, 1'b1, 8'h40},  // R1 read addr 0
    {8'h0B, 8'h00, 1'b1, 1'b1, 8'h45}   // R7 addr 5 untouched
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic       sdo, sdo_oe, we, re, rd_burst;
  logic [3:0] addr;
  logic [7:0] wdata, rdata;
  logic [7:0] mem [0:10];

  int n_tests = 0, n_fail = 0;
  int we_cnt = 0, re_cnt = 0, bst_cnt = 0;
  logic [3:0] last_addr;
  logic [7:0] last_data;
  logic [7:0] wbuf [16];
  logic [7:0] rbuf [16];
  logic       oe_all [16];
  logic       oe_any [16];
  logic [7:0] cur_rx;
  logic       cur_all, cur_any;

  always #4 clk = ~clk;

  lsb_reg_port dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .sdi_i(sdi),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe), .reg_addr_o(addr), .reg_wdata_o(wdata),
    .reg_we_o(we), .reg_re_o(re), .reg_rdata_i(rdata), .reg_rd_burst_o(rd_burst)
  );

  assign rdata = (addr <= 4'd10) ? mem[addr] : 8'hEE;

  initial for (int i = 0; i <= 10; i++) mem[i] = 8'h40 + 8'(i);

  always @(posedge clk) begin
    if (we) begin
      we_cnt <= we_cnt + 1;
      last_addr <= addr;
      last_data <= wdata;
      if (addr <= 4'd10) mem[addr] <= wdata;
    end
    if (re) re_cnt <= re_cnt + 1;
    if (rd_burst) bst_cnt <= bst_cnt + 1;
  end

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    cur_rx = '0; cur_all = 1'b1; cur_any = 1'b0;
    for (int i = 0; i < n; i++) begin
      sdi = b[i];
      wait_n(HALF);
      cur_rx[i] = sdo;
      cur_all &= sdo_oe;
      cur_any |= sdo_oe;
      sclk = 1'b1;
      wait_n(HALF);
      sclk = 1'b0;
    end
  endtask

  task automatic access(input logic [7:0] cmd, input int nb);
    cs_n = 1'b0;
    wait_n(HALF);
    send_bits(cmd, 8);
    for (int k = 0; k < nb; k++) begin
      send_bits(wbuf[k], 8);
      rbuf[k] = cur_rx; oe_all[k] = cur_all; oe_any[k] = cur_any;
    end
    wait_n(HALF);
    cs_n = 1'b1;
    wait_n(4 * HALF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual 0x0 expected 0x1");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int w0, r0, b0;
    wait_n(5);
    check(!we && !re && !rd_burst && !sdo_oe, "R11 reset outputs", {we, re, rd_burst, sdo_oe}, 0);
    rst_n = 1'b1;
    wait_n(5);

    for (int v = 0; v < NVEC; v++) begin
      logic [7:0] cmd, wd, er;
      logic es, eo;
      {cmd, wd, es, eo, er} = VEC[v];
      w0 = we_cnt; r0 = re_cnt; b0 = bst_cnt;
      wbuf[0] = wd;
      access(cmd, 1);
      if (!cmd[0]) begin
        check((we_cnt - w0) == int'(es), "R2 write strobe count", we_cnt - w0, int'(es));
        if (es) check(last_addr == cmd[4:1] && last_data == wd, "R1 write addr/data",
                      {last_addr, last_data}, {cmd[4:1], wd});
      end else begin
        check((re_cnt - r0) == int'(es), "R3 fetch count", re_cnt - r0, int'(es));
        check(bst_cnt == b0, "R10 single read not burst", bst_cnt - b0, 0);
      end
      check(oe_all[0] == eo && oe_any[0] == eo, "R8 sdo enable", oe_any[0], eo);
      if (eo) check(rbuf[0] == er, "R3 read byte", rbuf[0], er);
    end

    // R5 burst write from address 0, two bytes beyond the end (R6)
    w0 = we_cnt;
    for (int k = 0; k < 13; k++) wbuf[k] = 8'hA0 + 8'(k);
    access(8'h80, 13);
    check((we_cnt - w0) == 11, "R6 burst write strobes", we_cnt - w0, 11);
    check(last_addr == 4'd10 && last_data == 8'hAA, "R5 burst last write", {last_addr, last_data}, 12'hAAA);

    // R5 burst read with zero fill past the end (R6), burst flag (R10)
    r0 = re_cnt; b0 = bst_cnt;
    for (int k = 0; k < 13; k++) wbuf[k] = 8'h00;
    access(8'h81, 13);
    for (int k = 0; k < 13; k++) begin
      logic [7:0] e;
      e = (k <= 10) ? 8'hA0 + 8'(k) : 8'h00;
      check(rbuf[k] == e && oe_all[k], "R5 burst read byte", rbuf[k], e);
    end
    check((re_cnt - r0) == 11, "R6 burst fetch count", re_cnt - r0, 11);
    check((bst_cnt - b0) == 11, "R10 burst flag count", bst_cnt - b0, 11);

    // R5 burst bit with nonzero address: one byte, then idle
    r0 = re_cnt; b0 = bst_cnt;
    access(8'h87, 2);
    check(rbuf[0] == 8'hA3, "R5 single despite burst bit", rbuf[0], 8'hA3);
    check(!oe_any[1] && (re_cnt - r0) == 1, "R5 second byte ignored", re_cnt - r0, 1);
    check(bst_cnt == b0, "R10 no burst flag", bst_cnt - b0, 0);

    // R9 abort inside the data byte
    w0 = we_cnt;
    cs_n = 1'b0; wait_n(HALF);
    send_bits(8'h04, 8);
    send_bits(8'hF0, 5);
    cs_n = 1'b1; wait_n(4 * HALF);
    check(we_cnt == w0, "R9 partial byte dropped", we_cnt - w0, 0);
    wbuf[0] = 8'h00;
    access(8'h05, 1);
    check(rbuf[0] == 8'hA2, "R9 register kept, new command ok", rbuf[0], 8'hA2);

    // R12 activity with CS high
    w0 = we_cnt; r0 = re_cnt;
    for (int i = 0; i < 16; i++) begin
      sdi = 1'b1; sclk = 1'b1; wait_n(HALF);
      check(!sdo_oe, "R12 sdo off with cs high", sdo_oe, 0);
      sclk = 1'b0; wait_n(HALF);
    end
    check(we_cnt == w0 && re_cnt == r0, "R12 no strobes with cs high",
          we_cnt + re_cnt - w0 - r0, 0);
    access(8'h01, 1);
    check(rbuf[0] == 8'hA0, "R12 access after idle activity", rbuf[0], 8'hA0);

    // R11 reset in the middle of a read
    cs_n = 1'b0; wait_n(HALF);
    send_bits(8'h07, 8);
    send_bits(8'h00, 3);
    rst_n = 1'b0;
    wait_n(2);
    check(!we && !re && !rd_burst && !sdo_oe, "R11 outputs in reset", {we, re, rd_burst, sdo_oe}, 0);
    cs_n = 1'b1; wait_n(4);
    rst_n = 1'b1; wait_n(4 * HALF);
    access(8'h07, 1);
    check(rbuf[0] == 8'hA3, "R11 access after reset", rbuf[0], 8'hA3);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule